// File: doc/BRIEF.md
# Stereo Soft Mute with Per-Channel Silence Flags

This block sits in the per-sample path of a stereo audio pipeline and acts once per sample strobe. While mute is requested it walks the gain of both channels down in 0.5 dB decrements, one per sample. The output reaches exactly zero once the attenuation arrives at a floor of 120 dB. When mute is dropped the gain climbs back in 0.5 dB increments to unity. Muting therefore never cuts the signal hard. A resynchronisation input overrides everything: it forces both outputs to zero on the same strobe and returns the ramp to its start.

Each channel also has a counter of consecutive all-zero input samples. The channel's flag rises once that run reaches a threshold of 1024 samples. A single nonzero sample clears the counter and the flag. The two flags are independent. A small state machine tracks the ramp. Its states are PASS (unity gain, index 0), FALL (attenuating while muted), SILENT (at the floor, output zero), RISE (recovering after release) and HOLD (resync asserted). The transitions are: PASS→FALL on mute; FALL→SILENT when the index reaches the floor; FALL→RISE on release; SILENT→RISE on release; RISE→FALL on mute; RISE→PASS when the index returns to 0; any state→HOLD on resync; HOLD→PASS, or HOLD→FALL if mute is set, once resync drops.

Top module: `smz_softmute`

## Requirements
- R1: After reset both outputs are 0 and both zero flags are low.
- R2: Outputs and flags change only at a clock edge where `smp_stb` is high. With mute idle and the index at 0, each output equals its input sample exactly.
- R3: The gain index k rises by 1 at each strobe with `mute_req` high. Each step is 0.5 dB, and the coefficient is round(32768·10^(−(k mod 12)/40)) shifted right by floor(k/12). The output is (x·c + 16384) arithmetically shifted right by 15, saturated to 24 bits.
- R4: When the index reaches 240 (−120 dB) the outputs are exactly 0. The index holds there while mute stays high.
- R5: With `mute_req` low, the index falls by 1 per strobe until 0, where unity gain resumes.
- R6: A strobe with `resync` high drives both outputs to 0 and resets the index to 0. At the next unmuted strobe without resync the output equals the input.
- R7: A channel's zero flag goes high at the strobe that completes 1024 consecutive zero samples, and not earlier.
- R8: A nonzero sample on a channel clears that channel's flag and run count on the same strobe.
- R9: The left and right flags depend only on their own channel's samples.
- R10: Reversing mute in mid-ramp changes direction from the current index, without jumping.
- R11: A strobe with `resync` high clears both run counts and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| mute_req | input | 1 | Mute request, level |
| resync | input | 1 | Resynchronisation hold, level |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| zero_l | output | 1 | Left silence flag |
| zero_r | output | 1 | Right silence flag |

## Verification
The ramp is driven with pseudo-random samples, full-scale positive and negative samples, and small values, across every index from 0 to past the floor and back. This separates a wrong table entry, a wrong octave shift and wrong rounding, and it checks that the output is clamped to zero at the floor. A short fall followed by an early release shows whether the ramp turns around at the right index. The zero-run checks feed one channel silence and the other noise. They then break the run with a single nonzero sample, and finally fire a resync in the middle of a run. Together these tell apart off-by-one thresholds, flags shared across channels, and counters that survive resynchronisation.

// File: rtl/smz_pkg.sv
package smz_pkg;
    typedef enum logic [2:0] {
        ST_PASS,
        ST_FALL,
        ST_SILENT,
        ST_RISE,
        ST_HOLD
    } ramp_state_t;

    localparam int COEF_FRAC     = 15;
    localparam int COEF_W        = COEF_FRAC + 1;
    localparam int STEPS_PER_6DB = 12;
endpackage

// File: rtl/smz_gain_lut.sv
module smz_gain_lut
    import smz_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [COEF_W-1:0] coef
);
    logic [IDX_W-1:0]  phase_w;
    logic [IDX_W-1:0]  oct_w;
    logic [COEF_W-1:0] base_w;

    assign phase_w = idx % IDX_W'(STEPS_PER_6DB);
    assign oct_w   = idx / IDX_W'(STEPS_PER_6DB);

    always_comb begin
        unique case (phase_w)
            IDX_W'(0):  base_w = COEF_W'(32768);
            IDX_W'(1):  base_w = COEF_W'(30935);
            IDX_W'(2):  base_w = COEF_W'(29205);
            IDX_W'(3):  base_w = COEF_W'(27571);
            IDX_W'(4):  base_w = COEF_W'(26029);
            IDX_W'(5):  base_w = COEF_W'(24573);
            IDX_W'(6):  base_w = COEF_W'(23198);
            IDX_W'(7):  base_w = COEF_W'(21900);
            IDX_W'(8):  base_w = COEF_W'(20675);
            IDX_W'(9):  base_w = COEF_W'(19519);
            IDX_W'(10): base_w = COEF_W'(18427);
            IDX_W'(11): base_w = COEF_W'(17396);
            default:    base_w = '0;
        endcase
    end

    assign coef = base_w >> oct_w;
endmodule

// File: rtl/smz_scale.sv
module smz_scale
    import smz_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic        [COEF_W-1:0] coef,
    input  logic                     force_zero,
    output logic signed [DATA_W-1:0] y
);
    localparam int PROD_W = DATA_W + COEF_W + 1;
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [PROD_W-1:0] POS_LIM  = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] NEG_LIM  = -(PROD_W'(64'sd1 <<< (DATA_W - 1)));

    logic signed [PROD_W-1:0] prod_w;
    logic signed [PROD_W-1:0] shifted_w;

    always_comb begin
        prod_w    = $signed(x) * $signed({1'b0, coef});
        shifted_w = (prod_w + HALF_LSB) >>> COEF_FRAC;
        if (force_zero)
            y = '0;
        else if (shifted_w > POS_LIM)
            y = POS_LIM[DATA_W-1:0];
        else if (shifted_w < NEG_LIM)
            y = NEG_LIM[DATA_W-1:0];
        else
            y = shifted_w[DATA_W-1:0];
    end
endmodule

// File: rtl/smz_zero_watch.sv
module smz_zero_watch #(
    parameter int DATA_W   = 24,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              clr,
    input  logic [DATA_W-1:0] sample,
    output logic              flag
);
    localparam int CNT_W = $clog2(ZERO_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_END  = CNT_W'(ZERO_RUN);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(ZERO_RUN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (stb) begin
            if (clr || (sample != '0)) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end else if (cnt_q != RUN_END) begin
                cnt_q  <= cnt_q + 1'b1;
                flag_q <= (cnt_q == RUN_LAST);
            end
        end
    end

    assign flag = flag_q;

    p_clear_on_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && (sample != '0)) |=> !flag);
    p_flag_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(flag));
    p_clear_on_resync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && clr) |=> !flag);
endmodule

// File: rtl/smz_softmute.sv
module smz_softmute
    import smz_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int FLOOR_STEPS = 240,
    parameter int ZERO_RUN    = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_stb,
    input  logic                     mute_req,
    input  logic                     resync,
    input  logic signed [DATA_W-1:0] in_l,
    input  logic signed [DATA_W-1:0] in_r,
    output logic signed [DATA_W-1:0] out_l,
    output logic signed [DATA_W-1:0] out_r,
    output logic                     zero_l,
    output logic                     zero_r
);
    localparam int NUM_CH = 2;
    localparam int IDX_W  = $clog2(FLOOR_STEPS + 1);
    localparam logic [IDX_W-1:0] IDX_FLOOR = IDX_W'(FLOOR_STEPS);
    localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(0);

    ramp_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [COEF_W-1:0] coef_w;
    logic             silence_w;

    logic signed [DATA_W-1:0] ch_in     [NUM_CH];
    logic signed [DATA_W-1:0] ch_scaled [NUM_CH];
    logic signed [DATA_W-1:0] out_q     [NUM_CH];
    logic                     ch_zero   [NUM_CH];

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    // next-state and next-index logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (resync) begin
            state_d = ST_HOLD;
            idx_d   = IDX_TOP;
        end else begin
            unique case (state_q)
                ST_PASS, ST_HOLD: begin
                    if (mute_req) begin
                        idx_d   = IDX_W'(1);
                        state_d = (idx_d == IDX_FLOOR) ? ST_SILENT : ST_FALL;
                    end else begin
                        idx_d   = IDX_TOP;
                        state_d = ST_PASS;
                    end
                end
                ST_FALL, ST_RISE: begin
                    if (mute_req) begin
                        idx_d   = idx_q + 1'b1;
                        state_d = (idx_d == IDX_FLOOR) ? ST_SILENT : ST_FALL;
                    end else begin
                        idx_d   = idx_q - 1'b1;
                        state_d = (idx_d == IDX_TOP) ? ST_PASS : ST_RISE;
                    end
                end
                ST_SILENT: begin
                    if (!mute_req) begin
                        idx_d   = idx_q - 1'b1;
                        state_d = (idx_d == IDX_TOP) ? ST_PASS : ST_RISE;
                    end
                end
                default: begin
                    state_d = ST_HOLD;
                    idx_d   = IDX_TOP;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            idx_q   <= IDX_TOP;
        end else if (smp_stb) begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign silence_w = (state_d == ST_HOLD) || (state_d == ST_SILENT);

    smz_gain_lut #(.IDX_W(IDX_W)) gain_lut_i (
        .idx  (idx_d),
        .coef (coef_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        smz_scale #(.DATA_W(DATA_W)) scale_i (
            .x          (ch_in[c]),
            .coef       (coef_w),
            .force_zero (silence_w),
            .y          (ch_scaled[c])
        );
        smz_zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) zero_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (smp_stb),
            .clr    (resync),
            .sample (ch_in[c]),
            .flag   (ch_zero[c])
        );
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) out_q[c] <= '0;
        end else if (smp_stb) begin
            for (int c = 0; c < NUM_CH; c++) out_q[c] <= ch_scaled[c];
        end
    end

    assign out_l  = out_q[0];
    assign out_r  = out_q[1];
    assign zero_l = ch_zero[0];
    assign zero_r = ch_zero[1];

    function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
        logic signed [DATA_W:0] w;
        w = {v[DATA_W-1], v};
        return (w < 0) ? $unsigned(-w) : $unsigned(w);
    endfunction

    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && resync) |=> (out_l == '0) && (out_r == '0));
    p_silent_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SILENT) |-> (out_l == '0) && (out_r == '0));
    p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(out_l) && $stable(out_r));
    p_pass_unity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !resync && !mute_req && state_q == ST_PASS)
        |=> (out_l == $past(in_l)) && (out_r == $past(in_r)));
    p_gain_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (mag(out_l) <= mag($past(in_l))) && (mag(out_r) <= mag($past(in_r))));
    p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !resync && state_q == ST_FALL && !mute_req) |=> (state_q != ST_SILENT));
endmodule

// File: tb/smz_softmute_tb_top.sv
module smz_softmute_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FLOOR      = 240;
    localparam int RUN        = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic mute_req = 1'b0;
    logic resync = 1'b0;
    logic signed [23:0] in_l = '0;
    logic signed [23:0] in_r = '0;
    logic signed [23:0] out_l, out_r;
    logic zero_l, zero_r;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_idx = 0;
    int m_cl = 0;
    int m_cr = 0;
    logic signed [23:0] m_ol = '0;
    logic signed [23:0] m_or = '0;
    logic m_fl = 1'b0;
    logic m_fr = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    smz_softmute dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mute_req(mute_req),
        .resync(resync), .in_l(in_l), .in_r(in_r), .out_l(out_l),
        .out_r(out_r), .zero_l(zero_l), .zero_r(zero_r)
    );

    function automatic int coef_of(int idx);
        int k;
        int base;
        k = idx % 12;
        base = int'($floor(32768.0 * (10.0 ** (-real'(k) / 40.0)) + 0.5));
        return base >>> (idx / 12);
    endfunction

    function automatic logic signed [23:0] exp_out(logic signed [23:0] x, int idx);
        longint p;
        if (idx >= FLOOR) return '0;
        p = longint'(x) * longint'(coef_of(idx));
        p = (p + 64'sd16384) >>> 15;
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return p[23:0];
    endfunction

    function automatic logic signed [23:0] rnd24();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[31:8];
    endfunction

    task automatic chk(string tag, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic strobe(string tag, string ztag, logic signed [23:0] l,
                          logic signed [23:0] r, logic m, logic rs, bit hold);
        @(negedge clk);
        in_l = l; in_r = r; mute_req = m; resync = rs; smp_stb = 1'b1;
        if (rs) begin
            m_idx = 0; m_ol = '0; m_or = '0;
            m_cl = 0; m_cr = 0; m_fl = 0; m_fr = 0;
        end else begin
            if (m) m_idx = (m_idx < FLOOR) ? m_idx + 1 : FLOOR;
            else   m_idx = (m_idx > 0) ? m_idx - 1 : 0;
            m_ol = exp_out(l, m_idx);
            m_or = exp_out(r, m_idx);
            if (l != 0) m_cl = 0; else if (m_cl < RUN) m_cl++;
            if (r != 0) m_cr = 0; else if (m_cr < RUN) m_cr++;
            m_fl = (m_cl >= RUN);
            m_fr = (m_cr >= RUN);
        end
        @(negedge clk);
        smp_stb = 1'b0;
        chk(tag, "out_l", out_l, m_ol);
        chk(tag, "out_r", out_r, m_or);
        chk(ztag, "zero_l", zero_l, m_fl);
        chk(ztag, "zero_r", zero_r, m_fr);
        if (hold) begin
            in_l = ~l; in_r = ~r; mute_req = ~m;
            @(negedge clk);
            chk("R2", "held out_l", out_l, m_ol);
            chk("R2", "held out_r", out_r, m_or);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "out_l", out_l, 0);
        chk("R1", "out_r", out_r, 0);
        chk("R1", "zero_l", zero_l, 0);
        chk("R1", "zero_r", zero_r, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: unity pass-through, extremes and random
        strobe("R2", "R7", 24'sh7FFFFF, -24'sh800000, 0, 0, 1);
        strobe("R2", "R7", -24'sh800000, 24'sh7FFFFF, 0, 0, 1);
        strobe("R2", "R7", 24'sd1, -24'sd1, 0, 0, 1);
        for (int i = 0; i < 20; i++) strobe("R2", "R7", rnd24(), rnd24(), 0, 0, 1);

        // R3 / R4: full descent past the floor
        for (int i = 0; i < 250; i++) begin
            logic signed [23:0] a;
            a = (i % 3 == 0) ? 24'sh7FFFFF : ((i % 3 == 1) ? -24'sh800000 : rnd24());
            strobe((i < FLOOR - 1) ? "R3" : "R4", "R7", a, rnd24(), 1, 0, 0);
        end

        // R5: full recovery
        for (int i = 0; i < 250; i++) strobe("R5", "R7", rnd24(), rnd24(), 0, 0, 0);

        // R10: reversal mid-ramp
        for (int i = 0; i < 30; i++) strobe("R10", "R7", rnd24(), rnd24(), 1, 0, 0);
        for (int i = 0; i < 40; i++) strobe("R10", "R7", rnd24(), rnd24(), 0, 0, 0);

        // R6: resync forces zero, then restart at unity
        for (int i = 0; i < 10; i++) strobe("R6", "R7", rnd24(), rnd24(), 1, 0, 0);
        for (int i = 0; i < 3; i++) strobe("R6", "R11", 24'sh7FFFFF, -24'sh123456, 1, 1, 1);
        strobe("R6", "R7", 24'sh345678, -24'sh0ABCDE, 0, 0, 1);
        strobe("R6", "R7", rnd24(), rnd24(), 0, 0, 0);

        // R7 / R9: left silent, right noisy
        for (int i = 0; i < 1030; i++) strobe("R2", "R7 R9", '0, rnd24() | 24'sd1, 0, 0, 0);
        // R8: one nonzero sample clears left
        strobe("R2", "R8", 24'sd5, '0, 0, 0, 1);
        for (int i = 0; i < 1024; i++) strobe("R2", "R9", '0, '0, 0, 0, 0);
        // R11: resync clears both flags, run restarts
        strobe("R6", "R11", '0, '0, 0, 1, 1);
        for (int i = 0; i < 1024; i++) strobe("R2", "R11", '0, '0, 0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule